// File: doc/BRIEF.md
# Byte-Level I2C Bus Master

This block is an I2C bus master that a host drives one byte at a time through five byte-wide registers. The host sets a 16-bit clock divider and turns the core on through a control byte. It then writes a command byte that can ask for any mix of a start condition, one byte sent or received, a choice of acknowledge and a stop condition. On the bus side the block pulls SCL and SDA low through open-drain enables and reads the wires back through two-flop synchronisers.

Each command runs to completion in the background. During that time a progress bit in the status register stays set. When the command ends, a pending flag is raised, and that flag drives the interrupt output when interrupts are enabled. Arbitration loss, the slave's acknowledge and bus occupancy are also reported in status. Clock stretching by a slave is honoured because the bit engine does not move on while SCL is still held low.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both prescaler bytes read 0xFF and the control byte reads 0x00. Status reads 0x00, irq is low and neither sclOe nor sdaOe is asserted.
- R2: The register address selects as follows. 0 is the prescaler low byte and 1 is the prescaler high byte. 2 is control, which reads back all eight bits written; bit 7 turns the core on and bit 6 enables the interrupt. 3 takes the transmit byte on a write and returns the last received byte on a read. 4 is the command byte on a write and the status byte on a read.
- R3: A command write has no effect while the core is off or while a command is in progress. A command is not re-executed after it completes. Turning the core off releases both lines and ends any transfer.
- R4: With prescaler value P, each bus bit and each start or stop lasts five ticks of P+1 clocks. A one-byte write without start or stop keeps status bit 1 (in progress) high for 45·(P+1) clocks, with a latency of one or two clocks.
- R5: Command bit 4 sends the transmit byte MSB first and then samples the slave acknowledge into status bit 7 (1 = not acknowledged).
- R6: Command bit 5 receives a byte MSB first into register 3. Command bit 3 selects the acknowledge sent afterwards: 0 pulls SDA low (ACK), 1 leaves it released (NACK).
- R7: Command bit 7 produces a start condition (SDA falls while SCL is high), and bit 6 produces a stop condition after any byte. Command 0x91 gives start plus write, and 0x41 gives stop plus interrupt clear. Status bit 6 is set by a start seen on the bus and cleared by a stop seen on the bus.
- R8: Status bit 0 is set when a command completes. Writing a command with bit 0 set clears it. The irq output equals status bit 0 gated by control bit 6.
- R9: If SDA reads low at the sample point of a written bit while the master is releasing it, the transfer aborts. Both lines are released and status bits 5 and 0 are set. Status bit 5 clears when the next command is accepted.
- R10: A slave holding SCL low stretches the bit, and the transfer still completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regWe | input | 1 | Register write strobe |
| regRdata | output | 8 | Register read data (combinational from regAddr) |
| irq | output | 1 | Interrupt request |
| sclIn | input | 1 | SCL wire level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaIn | input | 1 | SDA wire level |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the slave changes SDA only while SCL is low, except for the deliberate jam used to force arbitration loss. They also assume a prescaler of at least 1, so that the synchronised line levels settle before the next tick. The bench keeps to these limits. Its slave model updates SDA only on falling SCL edges, the prescaler sweep stays between 3 and 6, and slave data is placed on the bus only after a start has left SCL low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_START_BIT = 7;
  localparam int CMD_STOP_BIT  = 6;
  localparam int CMD_RD_BIT    = 5;
  localparam int CMD_WR_BIT    = 4;
  localparam int CMD_NACK_BIT  = 3;
  localparam int CMD_IACK_BIT  = 0;

  typedef struct packed {
    logic start;
    logic stop;
    logic rd;
    logic wr;
    logic nack;
  } cmd_t;

  typedef struct packed {
    logic accept;
    logic sample;
    logic ackSample;
    logic rxLoad;
    logic done;
    logic arbLost;
  } strobe_t;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_START, ENG_BITS, ENG_ACK, ENG_STOP
  } engState_t;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs import i2cm_pkg::*; #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           stb,
  input  logic              engBusy,
  output logic              coreEn,
  output logic [2*DATA_W-1:0] prescale,
  output cmd_t              cmd,
  output logic              cmdValid,
  output logic              txBit,
  output logic              sclSync,
  output logic              sdaSync,
  output logic              tip,
  output logic              ifFlag,
  output logic              alFlag,
  output logic              rxAck,
  output logic [DATA_W-1:0] rxByte,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_PRE_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRE_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(4);

  logic [DATA_W-1:0] preLo, preHi, ctrlReg, txByte, shiftReg;
  logic sclMeta, sdaMeta, sdaPrev, busBusy, cmdWr, hasAction;
  logic [DATA_W-1:0] status;

  assign coreEn   = ctrlReg[7];
  assign irq      = ifFlag & ctrlReg[6];
  assign prescale = {preHi, preLo};
  assign tip      = cmdValid | engBusy;
  assign txBit    = shiftReg[DATA_W-1];
  assign cmdWr    = regWe && (regAddr == A_CMD);
  assign hasAction = regWdata[CMD_START_BIT] | regWdata[CMD_STOP_BIT] |
                     regWdata[CMD_RD_BIT] | regWdata[CMD_WR_BIT];
  assign status = {rxAck, busBusy, alFlag, 3'b000, tip, ifFlag};

  // line synchronisers and bus-state monitor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1; sclSync <= 1'b1;
      sdaMeta <= 1'b1; sdaSync <= 1'b1; sdaPrev <= 1'b1;
      busBusy <= 1'b0;
    end else begin
      sclMeta <= sclIn; sclSync <= sclMeta;
      sdaMeta <= sdaIn; sdaSync <= sdaMeta; sdaPrev <= sdaSync;
      if (sclSync && sdaPrev && !sdaSync)      busBusy <= 1'b1;
      else if (sclSync && !sdaPrev && sdaSync) busBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preLo <= '1; preHi <= '1; ctrlReg <= '0; txByte <= '0;
      cmd <= '0; cmdValid <= 1'b0;
      ifFlag <= 1'b0; alFlag <= 1'b0; rxAck <= 1'b0;
      shiftReg <= '0; rxByte <= '0;
    end else begin
      if (regWe && regAddr == A_PRE_LO) preLo <= regWdata;
      if (regWe && regAddr == A_PRE_HI) preHi <= regWdata;
      if (regWe && regAddr == A_CTRL)   ctrlReg <= regWdata;
      if (regWe && regAddr == A_DATA)   txByte <= regWdata;

      if (!coreEn || stb.accept) cmdValid <= 1'b0;
      else if (cmdWr && !tip && hasAction) begin
        cmdValid <= 1'b1;
        cmd <= '{start: regWdata[CMD_START_BIT], stop: regWdata[CMD_STOP_BIT],
                 rd: regWdata[CMD_RD_BIT], wr: regWdata[CMD_WR_BIT],
                 nack: regWdata[CMD_NACK_BIT]};
      end

      if (stb.done || stb.arbLost)             ifFlag <= 1'b1;
      else if (cmdWr && regWdata[CMD_IACK_BIT]) ifFlag <= 1'b0;

      if (stb.arbLost)     alFlag <= 1'b1;
      else if (stb.accept) alFlag <= 1'b0;

      if (stb.ackSample) rxAck <= sdaSync;
      if (stb.accept && cmd.wr) shiftReg <= txByte;
      else if (stb.sample)      shiftReg <= {shiftReg[DATA_W-2:0], sdaSync};
      if (stb.rxLoad) rxByte <= shiftReg;
    end
  end

  always_comb begin
    case (regAddr)
      A_PRE_LO: regRdata = preLo;
      A_PRE_HI: regRdata = preHi;
      A_CTRL:   regRdata = ctrlReg;
      A_DATA:   regRdata = rxByte;
      A_CMD:    regRdata = status;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreEn,
  input  logic [PRE_W-1:0] prescale,
  input  logic             cmdValid,
  input  cmd_t             cmd,
  input  logic             txBit,
  input  logic             sclSync,
  input  logic             sdaSync,
  output strobe_t          stb,
  output logic             engBusy,
  output logic             sclOe,
  output logic             sdaOe
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);
  localparam logic [2:0] PH_WAIT = 3'd2;
  localparam logic [2:0] PH_LAST = 3'd4;

  engState_t state;
  logic [2:0] phase;
  logic [IDX_W-1:0] bitIdx;
  logic [PRE_W-1:0] cnt;
  cmd_t cur;
  logic sendHigh, tick, go, lastPh, hasByte, readMode, writeMode, arbHit;

  assign engBusy = (state != ENG_IDLE);

  always_comb begin
    tick      = coreEn && (state != ENG_IDLE) && (cnt == '0);
    go        = tick && ((phase != PH_WAIT) || sclSync);
    lastPh    = (phase == PH_LAST);
    readMode  = cur.rd;
    writeMode = cur.wr && !cur.rd;
    hasByte   = cur.rd || cur.wr;
    arbHit    = go && state == ENG_BITS && phase == PH_WAIT && sendHigh && !sdaSync;
    stb           = '0;
    stb.accept    = (state == ENG_IDLE) && coreEn && cmdValid;
    stb.sample    = go && state == ENG_BITS && phase == PH_WAIT && !arbHit;
    stb.ackSample = go && state == ENG_ACK && phase == PH_WAIT && writeMode;
    stb.rxLoad    = go && state == ENG_ACK && phase == PH_WAIT && readMode;
    stb.arbLost   = arbHit;
    stb.done      = go && lastPh &&
                    ((state == ENG_START && !hasByte && !cur.stop) ||
                     (state == ENG_ACK && !cur.stop) || state == ENG_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ENG_IDLE; phase <= '0; bitIdx <= '0; cnt <= '0;
      cur <= '0; sendHigh <= 1'b0; sclOe <= 1'b0; sdaOe <= 1'b0;
    end else if (!coreEn) begin
      state <= ENG_IDLE; phase <= '0; cnt <= prescale;
      sclOe <= 1'b0; sdaOe <= 1'b0;
    end else begin
      if (state == ENG_IDLE || cnt == '0) cnt <= prescale;
      else                                cnt <= cnt - 1'b1;
      if (go) phase <= lastPh ? 3'd0 : phase + 3'd1;
      case (state)
        ENG_IDLE: if (cmdValid) begin
          cur <= cmd; phase <= '0; bitIdx <= '0;
          state <= cmd.start ? ENG_START : ((cmd.rd || cmd.wr) ? ENG_BITS : ENG_STOP);
        end
        ENG_START: if (go) begin
          case (phase)
            3'd0: sdaOe <= 1'b0;
            3'd1: sclOe <= 1'b0;
            3'd2: sdaOe <= 1'b1;
            3'd4: begin
              sclOe <= 1'b1;
              state <= hasByte ? ENG_BITS : (cur.stop ? ENG_STOP : ENG_IDLE);
            end
            default: ;
          endcase
        end
        ENG_BITS: if (go) begin
          case (phase)
            3'd0: begin sdaOe <= writeMode && !txBit; sendHigh <= writeMode && txBit; end
            3'd1: sclOe <= 1'b0;
            3'd2: if (arbHit) begin
              state <= ENG_IDLE; phase <= '0; sclOe <= 1'b0; sdaOe <= 1'b0;
            end
            3'd4: begin
              sclOe <= 1'b1; bitIdx <= bitIdx + 1'b1;
              if (bitIdx == LAST_IDX) state <= ENG_ACK;
            end
            default: ;
          endcase
        end
        ENG_ACK: if (go) begin
          case (phase)
            3'd0: sdaOe <= readMode && !cur.nack;
            3'd1: sclOe <= 1'b0;
            3'd4: begin sclOe <= 1'b1; state <= cur.stop ? ENG_STOP : ENG_IDLE; end
            default: ;
          endcase
        end
        ENG_STOP: if (go) begin
          case (phase)
            3'd0: sdaOe <= 1'b1;
            3'd1: sclOe <= 1'b0;
            3'd3: sdaOe <= 1'b0;
            3'd4: state <= ENG_IDLE;
            default: ;
          endcase
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master import i2cm_pkg::*; #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  input  logic              sclIn,
  output logic              sclOe,
  input  logic              sdaIn,
  output logic              sdaOe
);
  localparam int PRE_W = 2 * DATA_W;

  strobe_t stb;
  cmd_t cmd;
  logic coreEn, cmdValid, txBit, sclSync, sdaSync, engBusy;
  logic tip, ifFlag, alFlag, rxAck;
  logic [PRE_W-1:0] prescale;
  logic [DATA_W-1:0] rxByte;

  i2cm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .sclIn(sclIn), .sdaIn(sdaIn),
    .stb(stb), .engBusy(engBusy), .coreEn(coreEn), .prescale(prescale),
    .cmd(cmd), .cmdValid(cmdValid), .txBit(txBit), .sclSync(sclSync),
    .sdaSync(sdaSync), .tip(tip), .ifFlag(ifFlag), .alFlag(alFlag),
    .rxAck(rxAck), .rxByte(rxByte), .irq(irq)
  );

  i2cm_engine #(.PRE_W(PRE_W)) u_engine (
    .clk(clk), .rstN(rstN), .coreEn(coreEn), .prescale(prescale),
    .cmdValid(cmdValid), .cmd(cmd), .txBit(txBit), .sclSync(sclSync),
    .sdaSync(sdaSync), .stb(stb), .engBusy(engBusy), .sclOe(sclOe),
    .sdaOe(sdaOe)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              coreEn,
  input logic              tip,
  input logic              ifFlag,
  input logic              alFlag,
  input logic              rxAck,
  input logic [DATA_W-1:0] rxByte,
  input logic              sclOe,
  input logic              sdaOe
);
  p_lines_free_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !coreEn |=> (!sclOe && !sdaOe && !tip));

  p_if_follows_tip_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ifFlag) |-> $past(tip));

  p_arb_releases_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alFlag) |-> (!sclOe && !sdaOe && !tip));

  p_rxack_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tip |=> $stable(rxAck));

  p_rxbyte_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    !tip |=> $stable(rxByte));
endmodule

bind i2c_byte_master i2cm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .coreEn(coreEn), .tip(tip), .ifFlag(ifFlag),
  .alFlag(alFlag), .rxAck(rxAck), .rxByte(rxByte), .sclOe(sclOe), .sdaOe(sdaOe)
);

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic regWe = 1'b0;
  logic [7:0] regRdata;
  logic irq, sclOe, sdaOe;
  logic slvSdaLow = 1'b0;
  logic slvSclLow = 1'b0;
  logic sclBus, sdaBus;

  assign sclBus = !(sclOe || slvSclLow);
  assign sdaBus = !(sdaOe || slvSdaLow);

  always #5 clk = ~clk;

  i2c_byte_master u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .irq(irq), .sclIn(sclBus),
    .sclOe(sclOe), .sdaIn(sdaBus), .sdaOe(sdaOe)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // bench slave: 1 ack writes, 2 nack writes, 3 drive read data, 4 jam SDA at bit 2
  int mode = 0;
  int bitCnt = 0;
  int startCnt = 0;
  int stretchCycles = 0;
  logic [7:0] slvTx = '0;
  logic [7:0] gotByte = '0;
  logic gotAck = 1'b0;

  function automatic logic wantLow(input int k);
    case (mode)
      1: return (k == 8);
      3: return (k < 8) ? !slvTx[7-k] : 1'b0;
      4: return (k == 2);
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge sdaBus) if (sclBus) begin bitCnt = 0; startCnt++; end

  always @(posedge sclBus) begin
    if (bitCnt < 8) gotByte = {gotByte[6:0], sdaBus};
    else if (bitCnt == 8) gotAck = sdaBus;
    bitCnt++;
  end

  always @(negedge sclBus) begin
    slvSdaLow = wantLow(bitCnt);
    if (stretchCycles > 0) begin
      slvSclLow = 1'b1;
      repeat (stretchCycles) @(posedge clk);
      slvSclLow = 1'b0;
    end
  end

  task automatic arm(input int m);
    mode = m; bitCnt = 0; slvSdaLow = wantLow(0);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1; v = regRdata;
  endtask

  task automatic waitIdle(output int n);
    logic [7:0] s;
    n = 0;
    do begin rd(3'd4, s); n++; end while (s[1] && n < 20000);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd4, v); chk("R1 status", v, 8'h00);
    rd(3'd0, v); chk("R1 prescale low", v, 8'hFF);
    rd(3'd1, v); chk("R1 prescale high", v, 8'hFF);
    rd(3'd2, v); chk("R1 control", v, 8'h00);
    chk("R1 irq/lines", {irq, sclOe, sdaOe}, 3'b000);

    // R2 register map
    wr(3'd0, 8'h03); wr(3'd1, 8'h00);
    rd(3'd0, v); chk("R2 prescale low", v, 8'h03);
    rd(3'd1, v); chk("R2 prescale high", v, 8'h00);
    wr(3'd2, 8'h3F); rd(3'd2, v); chk("R2 control readback", v, 8'h3F);

    // R3 core off: command ignored
    wr(3'd4, 8'h91); rd(3'd4, v); chk("R3 cmd ignored when off", v, 8'h00);
    idleCycles(100);
    chk("R3 lines released when off", {sclOe, sdaOe}, 2'b00);

    wr(3'd2, 8'h80);
    // R7 start only
    wr(3'd4, 8'h80); waitIdle(n);
    idleCycles(4);
    rd(3'd4, v); chk("R7 busy after start, R8 flag", {v[6], v[0]}, 2'b11);
    chk("R8 irq masked", irq, 1'b0);
    wr(3'd4, 8'h01); rd(3'd4, v); chk("R8 IACK clears flag", v[0], 1'b0);

    // R5 write with ACK, second command during transfer ignored (R3)
    wr(3'd3, 8'hA5); arm(1);
    wr(3'd4, 8'h10); idleCycles(20); wr(3'd4, 8'h40);
    waitIdle(n);
    chk("R5 byte on bus", gotByte, 8'hA5);
    rd(3'd4, v); chk("R5 ack received", v[7], 1'b0);
    idleCycles(150);
    rd(3'd4, v); chk("R3 no rerun and stop ignored", {v[6], v[1]}, 2'b10);

    // R5 write with NACK
    wr(3'd3, 8'h3C); arm(2); wr(3'd4, 8'h10); waitIdle(n);
    chk("R5 byte 3C", gotByte, 8'h3C);
    rd(3'd4, v); chk("R5 nack seen", v[7], 1'b1);

    // R6 reads
    slvTx = 8'h5A; arm(3); wr(3'd4, 8'h21); waitIdle(n);
    rd(3'd3, v); chk("R6 read data ack", v, 8'h5A);
    chk("R6 master sent ACK", gotAck, 1'b0);
    slvTx = 8'hC3; arm(3); wr(3'd4, 8'h29); waitIdle(n);
    rd(3'd3, v); chk("R6 read data nack", v, 8'hC3);
    chk("R6 master sent NACK", gotAck, 1'b1);

    // R7/R8 stop with interrupt clear, irq enabled
    arm(0);
    wr(3'd2, 8'hC0);
    chk("R8 irq with flag pending", irq, 1'b1);
    wr(3'd4, 8'h41);
    rd(3'd4, v); chk("R8 flag cleared by 0x41", {v[1], v[0]}, 2'b10);
    waitIdle(n); idleCycles(4);
    rd(3'd4, v); chk("R7 stop clears busy", {v[6], v[0]}, 2'b01);
    chk("R8 irq raised", irq, 1'b1);
    chk("R7 lines released", {sclOe, sdaOe}, 2'b00);
    wr(3'd4, 8'h01); chk("R8 irq cleared", irq, 1'b0);

    // R7 combined start+write
    n = startCnt;
    mode = 1; wr(3'd3, 8'h6E); wr(3'd4, 8'h91); waitIdle(n);
    chk("R7 0x91 byte", gotByte, 8'h6E);
    chk("R7 start seen", startCnt > 0, 1'b1);
    rd(3'd4, v); chk("R7 busy after 0x91", {v[7], v[6]}, 2'b01);
    wr(3'd4, 8'h01);

    // R4 prescaler sweep
    for (int p = 3; p <= 6; p++) begin
      logic [7:0] d;
      d = 8'(8'h81 + p * 8'h11);
      wr(3'd0, 8'(p)); wr(3'd3, d); arm(1);
      wr(3'd4, 8'h10); waitIdle(n);
      chk("R4 bus byte in sweep", gotByte, d);
      chk("R4 byte duration window",
          (n >= 45 * (p + 1) + 1 && n <= 45 * (p + 1) + 3), 1'b1);
      if (!(n >= 45 * (p + 1) + 1 && n <= 45 * (p + 1) + 3))
        $display("  R4 p=%0d measured=%0d", p, n);
    end
    wr(3'd0, 8'h03);
    base = 45 * 4 + 1;

    // R10 clock stretching
    stretchCycles = 40; wr(3'd3, 8'h96); arm(1);
    wr(3'd4, 8'h10); waitIdle(n);
    chk("R10 stretched byte", gotByte, 8'h96);
    chk("R10 stretch lengthens byte", n > base + 100, 1'b1);
    stretchCycles = 0; idleCycles(80);
    rd(3'd4, v); chk("R10 ack after stretch", v[7], 1'b0);
    wr(3'd4, 8'h01);

    // R9 arbitration loss
    wr(3'd3, 8'hFF); arm(4); wr(3'd4, 8'h10); waitIdle(n);
    rd(3'd4, v); chk("R9 lost and flag", {v[5], v[1], v[0]}, 3'b101);
    chk("R9 lines released", {sclOe, sdaOe}, 2'b00);
    arm(0); slvSdaLow = 1'b0; idleCycles(20);
    wr(3'd4, 8'h01);
    wr(3'd4, 8'h80); waitIdle(n); idleCycles(4);
    rd(3'd4, v); chk("R9 lost cleared on accept", {v[6], v[5]}, 2'b10);
    wr(3'd4, 8'h41); waitIdle(n);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule